// File: doc/BRIEF.md
# SIMD Lane Divergence Mask Unit

This block decides which lanes of an eight-lane SIMD datapath commit their results while every lane follows one shared instruction stream. When the sequencer issues a conditional, it presents one condition bit per lane. The block narrows the lane write-enable mask to the lanes whose bit is true, and the taken path then issues under that mask. At the else marker the block switches to the complementary lanes of the same parent. At the end-if marker it restores the parent mask, so full-width execution resumes at the point where the paths reconverge.

Nested conditionals are kept on a small stack of saved parent masks and saved condition bits. Its depth is a parameter with a default of four. A push onto a full stack, and an else or end-if with nothing on the stack, each set a sticky error flag. The block also reports the number of enabled lanes, which serves utilisation measurement. It raises a path-empty flag whenever no lane is enabled, so that the sequencer can branch past that path. All outputs are registered and reflect a marker on the cycle after the clock edge that samples it.

Top module: `simd_mask_ctrl`

## Requirements
- R1: After synchronous reset all lanes are enabled (`lane_we_o` all ones), `active_lanes_o` equals LANES, and `path_empty_o` and `nest_err_o` are 0.
- R2: A conditional-start marker (`br_if_i`=1) with the stack not full saves the current mask and `lane_cond_i`, and the next mask is the current mask AND `lane_cond_i`. Bit i of every lane vector belongs to lane i.
- R3: An else marker with a non-empty stack sets the mask to the saved parent mask AND NOT the condition bits saved at the matching start marker. The value on `lane_cond_i` during the else cycle has no effect.
- R4: An end-if marker with a non-empty stack restores the saved parent mask and removes that entry. Whenever the stack is empty, the mask is all ones.
- R5: Conditionals nest up to DEPTH levels. An inner start marker narrows the mask of the enclosing path, and inner else and end-if markers act relative to that enclosing path.
- R6: `active_lanes_o` always equals the number of ones in `lane_we_o`.
- R7: `path_empty_o` is 1 exactly when `lane_we_o` is all zeros.
- R8: A start marker while DEPTH entries are held sets `nest_err_o` and leaves the mask and the stack unchanged.
- R9: An else or end-if marker while the stack is empty sets `nest_err_o` and leaves the mask unchanged.
- R10: Once set, `nest_err_o` stays 1 until reset.
- R11: When more than one marker is high in one cycle, the start marker wins over else, and else wins over end-if. Only the winner acts.
- R12: In a cycle with no marker high, the mask is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_if_i | input | 1 | Conditional-start marker |
| br_else_i | input | 1 | Else marker |
| br_end_i | input | 1 | End-if (reconvergence) marker |
| lane_cond_i | input | LANES | Per-lane condition bits, sampled with the start marker |
| lane_we_o | output | LANES | Per-lane write-enable mask for the issued instruction |
| active_lanes_o | output | $clog2(LANES+1) | Number of enabled lanes |
| path_empty_o | output | 1 | No lane enabled; the current path may be skipped |
| nest_err_o | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The assertions assume that the marker inputs hold known values in every cycle after reset, and that the stack depth they observe is the level counter carried beside the mask. Where several markers are high together, they check only the winner's effect. The directed stimulus drives each marker for exactly one cycle. It keeps every scenario within DEPTH levels, except for the dedicated overflow and underflow cases, and it resets between those cases so that the sticky flag does not hide later results.

// File: rtl/simd_mask_pkg.sv
package simd_mask_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_IF   = 2'd1,
    OP_ELSE = 2'd2,
    OP_END  = 2'd3
  } mask_op_e;

  // Fixed priority: start marker over else, else over end-if
  function automatic mask_op_e decode_op(input logic f_if,
                                         input logic f_else,
                                         input logic f_end);
    if (f_if)        return OP_IF;
    else if (f_else) return OP_ELSE;
    else if (f_end)  return OP_END;
    else             return OP_NONE;
  endfunction

endpackage

// File: rtl/simd_mask_stack.sv
module simd_mask_stack #(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [LANES-1:0] par_i,
  input  logic [LANES-1:0] cond_i,
  output logic [LANES-1:0] top_par_o,
  output logic [LANES-1:0] top_cond_o,
  output logic [PW-1:0]    level_o
);

  localparam int EW = 2 * LANES;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr;
  logic [PW-1:0] ptr_m1;
  logic [EW-1:0] rd_word;

  assign ptr_m1 = ptr - PW'(1);

  // Storage has no reset so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (push_i) mem[ptr[AW-1:0]] <= {par_i, cond_i};
  end

  always_ff @(posedge clk) begin
    if (rst)         ptr <= '0;
    else if (push_i) ptr <= ptr + PW'(1);
    else if (pop_i)  ptr <= ptr_m1;
  end

  assign rd_word    = mem[ptr_m1[AW-1:0]];
  assign top_par_o  = rd_word[EW-1:LANES];
  assign top_cond_o = rd_word[LANES-1:0];
  assign level_o    = ptr;

endmodule

// File: rtl/simd_lane_popcount.sv
module simd_lane_popcount #(
  parameter int LANES = 8,
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] mask_i,
  output logic [CW-1:0]    count_o
);

  logic [CW-1:0] part [LANES+1];

  assign part[0] = '0;

  for (genvar g = 0; g < LANES; g++) begin : g_acc
    assign part[g+1] = part[g] + CW'(mask_i[g]);
  end

  assign count_o = part[LANES];

endmodule

// File: rtl/simd_mask_ctrl.sv
module simd_mask_ctrl #(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(LANES + 1),
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_if_i,
  input  logic             br_else_i,
  input  logic             br_end_i,
  input  logic [LANES-1:0] lane_cond_i,
  output logic [LANES-1:0] lane_we_o,
  output logic [CW-1:0]    active_lanes_o,
  output logic             path_empty_o,
  output logic             nest_err_o
);
  import simd_mask_pkg::*;

  mask_op_e         op;
  logic [LANES-1:0] top_par;
  logic [LANES-1:0] top_cond;
  logic [PW-1:0]    lvl;
  logic             st_full;
  logic             st_empty;
  logic             do_push;
  logic             do_pop;
  logic             err_ev;
  logic [LANES-1:0] mask_d;
  logic [CW-1:0]    cnt_d;

  assign op       = decode_op(br_if_i, br_else_i, br_end_i);
  assign st_full  = (lvl == PW'(DEPTH));
  assign st_empty = (lvl == '0);

  assign do_push = (op == OP_IF)  && !st_full;
  assign do_pop  = (op == OP_END) && !st_empty;
  assign err_ev  = ((op == OP_IF) && st_full) ||
                   (((op == OP_ELSE) || (op == OP_END)) && st_empty);

  simd_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) stack_i (
    .clk        (clk),
    .rst        (rst),
    .push_i     (do_push),
    .pop_i      (do_pop),
    .par_i      (lane_we_o),
    .cond_i     (lane_cond_i),
    .top_par_o  (top_par),
    .top_cond_o (top_cond),
    .level_o    (lvl)
  );

  always_comb begin
    mask_d = lane_we_o;
    unique case (op)
      OP_IF:   if (!st_full)  mask_d = lane_we_o & lane_cond_i;
      OP_ELSE: if (!st_empty) mask_d = top_par & ~top_cond;
      OP_END:  if (!st_empty) mask_d = top_par;
      default: mask_d = lane_we_o;
    endcase
  end

  simd_lane_popcount #(.LANES(LANES)) pop_i (
    .mask_i  (mask_d),
    .count_o (cnt_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_we_o      <= '1;
      active_lanes_o <= CW'(LANES);
      path_empty_o   <= 1'b0;
      nest_err_o     <= 1'b0;
    end else begin
      lane_we_o      <= mask_d;
      active_lanes_o <= cnt_d;
      path_empty_o   <= (mask_d == '0);
      nest_err_o     <= nest_err_o | err_ev;
    end
  end

endmodule

// File: rtl/simd_mask_chk.sv
module simd_mask_chk #(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(LANES + 1),
  localparam int PW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             br_if_i,
  input logic             br_else_i,
  input logic             br_end_i,
  input logic [LANES-1:0] lane_cond_i,
  input logic [LANES-1:0] lane_we_o,
  input logic [CW-1:0]    active_lanes_o,
  input logic             path_empty_o,
  input logic             nest_err_o,
  input logic [PW-1:0]    lvl
);

  assert_count_R6: assert property (@(posedge clk) disable iff (rst)
    active_lanes_o == CW'($countones(lane_we_o)));

  assert_empty_R7: assert property (@(posedge clk) disable iff (rst)
    path_empty_o == (lane_we_o == '0));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    nest_err_o |=> nest_err_o);

  assert_base_R4: assert property (@(posedge clk) disable iff (rst)
    (lvl == '0) |-> (lane_we_o == '1));

  assert_narrow_R2: assert property (@(posedge clk) disable iff (rst)
    (br_if_i && lvl != PW'(DEPTH)) |=>
      (lane_we_o == ($past(lane_we_o) & $past(lane_cond_i))));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (br_if_i && lvl == PW'(DEPTH)) |=> (nest_err_o && $stable(lane_we_o)));

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    (!br_if_i && (br_else_i || br_end_i) && lvl == '0) |=>
      (nest_err_o && $stable(lane_we_o)));

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!br_if_i && !br_else_i && !br_end_i) |=> $stable(lane_we_o));

endmodule

bind simd_mask_ctrl simd_mask_chk #(.LANES(LANES), .DEPTH(DEPTH)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .br_if_i        (br_if_i),
  .br_else_i      (br_else_i),
  .br_end_i       (br_end_i),
  .lane_cond_i    (lane_cond_i),
  .lane_we_o      (lane_we_o),
  .active_lanes_o (active_lanes_o),
  .path_empty_o   (path_empty_o),
  .nest_err_o     (nest_err_o),
  .lvl            (lvl)
);

// File: tb/simd_mask_ctrl_tb.sv
`timescale 1ns/1ps
module simd_mask_ctrl_tb_top;
  localparam int LANES = 8;
  localparam int DEPTH = 4;
  localparam int CW    = $clog2(LANES + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             br_if_i = 1'b0, br_else_i = 1'b0, br_end_i = 1'b0;
  logic [LANES-1:0] lane_cond_i = '0;
  logic [LANES-1:0] lane_we_o;
  logic [CW-1:0]    active_lanes_o;
  logic             path_empty_o;
  logic             nest_err_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state, built from the requirements
  logic [LANES-1:0] m_mask;
  logic [LANES-1:0] m_par  [DEPTH];
  logic [LANES-1:0] m_cond [DEPTH];
  int               m_lvl;
  bit               m_err;

  always #2.5 clk = ~clk;

  simd_mask_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) dut_i (
    .clk, .rst, .br_if_i, .br_else_i, .br_end_i, .lane_cond_i,
    .lane_we_o, .active_lanes_o, .path_empty_o, .nest_err_o
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ones(logic [LANES-1:0] v);
    int c = 0;
    for (int k = 0; k < LANES; k++) c += v[k];
    return c;
  endfunction

  task automatic check_all(string tag);
    chk({tag, " mask"},  32'(lane_we_o), 32'(m_mask));
    chk({tag, " R6 count"}, 32'(active_lanes_o), 32'(ones(m_mask)));
    chk({tag, " R7 empty"}, 32'(path_empty_o), 32'(m_mask == '0));
    chk({tag, " err"},   32'(nest_err_o), 32'(m_err));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_mask = '1; m_lvl = 0; m_err = 0;
  endtask

  task automatic step(logic i, logic e, logic n, logic [LANES-1:0] c, string tag);
    @(negedge clk);
    br_if_i = i; br_else_i = e; br_end_i = n; lane_cond_i = c;
    if (i) begin
      if (m_lvl == DEPTH) m_err = 1;
      else begin
        m_par[m_lvl] = m_mask; m_cond[m_lvl] = c; m_lvl++;
        m_mask = m_mask & c;
      end
    end else if (e) begin
      if (m_lvl == 0) m_err = 1;
      else m_mask = m_par[m_lvl-1] & ~m_cond[m_lvl-1];
    end else if (n) begin
      if (m_lvl == 0) m_err = 1;
      else begin m_lvl--; m_mask = m_par[m_lvl]; end
    end
    @(posedge clk);
    #1;
    br_if_i = 0; br_else_i = 0; br_end_i = 0; lane_cond_i = '0;
    check_all(tag);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 mask", 32'(lane_we_o), 32'hFF);
    chk("R1 count", 32'(active_lanes_o), 32'd8);
    chk("R1 empty", 32'(path_empty_o), 32'd0);
    chk("R1 err", 32'(nest_err_o), 32'd0);
  endtask

  task automatic t_basic();
    step(1, 0, 0, 8'b0000_0111, "R2 if");
    chk("R2 literal", 32'(lane_we_o), 32'h07);
    chk("R6 literal", 32'(active_lanes_o), 32'd3);
    step(0, 1, 0, 8'b1010_1010, "R3 else");
    chk("R3 literal cond ignored", 32'(lane_we_o), 32'hF8);
    step(0, 0, 1, 8'h00, "R4 end");
    chk("R4 literal", 32'(lane_we_o), 32'hFF);
  endtask

  task automatic t_nested();
    step(1, 0, 0, 8'b1111_0000, "R5 l1");
    step(1, 0, 0, 8'b1100_1100, "R5 l2");
    chk("R5 l2 literal", 32'(lane_we_o), 32'hC0);
    step(1, 0, 0, 8'b1000_0001, "R5 l3");
    step(1, 0, 0, 8'b1111_1111, "R5 l4");
    chk("R5 l4 literal", 32'(lane_we_o), 32'h80);
    step(0, 0, 1, 8'h00, "R5 pop4");
    step(0, 1, 0, 8'h00, "R5 else3");
    chk("R5 else3 literal", 32'(lane_we_o), 32'h40);
    step(0, 0, 1, 8'h00, "R5 pop3");
    step(0, 1, 0, 8'hFF, "R5 else2");
    chk("R5 else2 literal", 32'(lane_we_o), 32'h30);
    step(0, 0, 1, 8'h00, "R5 pop2");
    step(0, 0, 1, 8'h00, "R4 pop1");
  endtask

  task automatic t_skip_single();
    step(1, 0, 0, 8'h00, "R7 zero path");
    chk("R7 literal", 32'(path_empty_o), 32'd1);
    step(0, 1, 0, 8'h00, "R7 full else");
    chk("R7 else literal", 32'(path_empty_o), 32'd0);
    step(0, 0, 1, 8'h00, "R4 end");
    step(1, 0, 0, 8'b0001_0000, "R6 one lane");
    chk("R6 one lane literal", 32'(active_lanes_o), 32'd1);
    step(0, 0, 1, 8'h00, "R4 end");
  endtask

  task automatic t_priority_idle();
    step(1, 1, 1, 8'b0011_1100, "R11 if wins");
    chk("R11 literal", 32'(lane_we_o), 32'h3C);
    step(0, 1, 1, 8'h00, "R11 else wins");
    chk("R11 else literal", 32'(lane_we_o), 32'hC3);
    step(0, 0, 0, 8'hFF, "R12 idle");
    chk("R12 literal", 32'(lane_we_o), 32'hC3);
    step(0, 0, 1, 8'h00, "R4 end");
  endtask

  task automatic t_overflow();
    do_reset();
    for (int k = 0; k < DEPTH; k++) step(1, 0, 0, ~(8'h01 << k), "R5 fill");
    step(1, 0, 0, 8'h00, "R8 overflow");
    chk("R8 err literal", 32'(nest_err_o), 32'd1);
    chk("R8 mask literal", 32'(lane_we_o), 32'hF0);
    step(0, 0, 1, 8'h00, "R8 stack intact");
    chk("R8 pop literal", 32'(lane_we_o), 32'hF8);
    step(0, 0, 0, 8'h00, "R10 sticky");
    chk("R10 literal", 32'(nest_err_o), 32'd1);
  endtask

  task automatic t_underflow();
    do_reset();
    step(0, 0, 1, 8'h00, "R9 end empty");
    chk("R9 literal", 32'(nest_err_o), 32'd1);
    do_reset();
    step(0, 1, 0, 8'h0F, "R9 else empty");
    chk("R9 else mask literal", 32'(lane_we_o), 32'hFF);
    step(0, 0, 0, 8'h00, "R10 hold");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_nested();
    t_skip_single();
    t_priority_idle();
    t_overflow();
    t_underflow();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule